// File: doc/BRIEF.md
# Single-Shot Byte Copy Engine with Local Scratch Buffer

This block moves a block of bytes, one transfer at a time, between an on-chip scratch buffer of 4096 bytes and an external memory reached through a simple request/grant master port. Software sets up four registers: a source address, a destination address, a byte count and a command word. Any of them can be written with a 32-bit or a 64-bit access. The local buffer sits at a fixed window that starts at device address 0x40000. Command bit 1 tells the engine which side of the copy is local. That side's address is taken relative to the window base. The other side's address is ANDed with a 28-bit mask before it goes out on the bus.

A transfer starts when a command with its run bit set is written. It then waits a fixed number of clock cycles before the first beat. After that it moves one byte for each accepted master-port beat, in ascending address order. When it finishes, the run bit clears, and if the command asked for it, interrupt cause 0x00000100 is raised for one cycle. The setup registers cannot be changed while a transfer is running. Two flags report address problems but never stop the copy. One shows that the external address lost bits to the mask. The other shows that the local span left the window or wrapped around. Software and the test environment load and inspect the buffer through a direct byte port.

Top module: `lbuf_dma`

## Requirements
- R1: Register offsets are source 0x80, destination 0x88, count 0x90 and command 0x98. reg_size 2'b11 is a 64-bit access and 2'b10 is a 32-bit access. A 32-bit write replaces the whole register with the zero-extended low word, and a 32-bit read returns the low word with the upper half zero. Writes of any other size are ignored. Reads of any other size, and reads of an unmapped offset, return all ones.
- R2: After a synchronous active-low reset, all four registers read zero, m_req is low, irq_raise is zero and both flags are low.
- R3: While command bit 0 (run) is set, writes to the source, destination, count and command registers have no effect.
- R4: A command write whose bit 0 is 0 changes nothing and starts nothing.
- R5: If the accepted command write takes effect at clock edge k, the first m_req is high in the cycle that follows edge k+START_DELAY.
- R6: With command bit 1 = 0, byte i is read from external address (src & mask)+i and stored at buffer index dst−0x40000+i. With bit 1 = 1, buffer byte src−0x40000+i is written to external address (dst & mask)+i. Beats go out in ascending i, one byte per granted beat, and m_req is never high without the run bit.
- R7: The mask keeps the low 28 bits of the external address. The addr_clamped flag goes high at transfer start when any masked-off bit was set, and low otherwise.
- R8: The range_err flag goes high at transfer start when the local span [L, L+count) starts below 0x40000, ends above 0x41000, or wraps around 2^64. Copying still proceeds, with the buffer index taken modulo 4096.
- R9: On completion the run bit clears and the other command bits are kept. irq_raise equals 32'h00000100 for exactly one cycle, just before the run bit reads 0, if command bit 2 was set. Otherwise it stays zero.
- R10: A count of zero completes after the start delay without raising m_req.
- R11: A request holds m_req, m_addr and m_we stable until m_gnt. Read data is taken in the cycle m_rvalid is high, and m_rvalid must come at least one cycle after the grant.
- R12: The byte port writes buffer[buf_addr] on a clock edge when buf_wen is high, and buf_rdata shows buffer[buf_addr] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_size | input | 2 | Access size code (2'b10 = 32-bit, 2'b11 = 64-bit) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| buf_wen | input | 1 | Buffer byte write strobe |
| buf_addr | input | 12 | Buffer byte index |
| buf_wdata | input | 8 | Buffer write byte |
| buf_rdata | output | 8 | Buffer read byte |
| m_req | output | 1 | Master beat request |
| m_we | output | 1 | Beat is a write to external memory |
| m_addr | output | 28 | External byte address |
| m_wdata | output | 8 | Write byte |
| m_gnt | input | 1 | Beat accepted |
| m_rvalid | input | 1 | Read byte valid |
| m_rdata | input | 8 | Read byte |
| irq_raise | output | 32 | Interrupt cause, pulsed at completion |
| range_err | output | 1 | Local span out of window |
| addr_clamped | output | 1 | External address altered by mask |

## Verification
The copy is tried in both directions. An outbound copy with an immediate grant shows whether the ordering, the buffer offset and the start delay are right. An inbound copy with a stalled grant and an address above the 28-bit mask tells a correct hold-until-grant and masking apart from a design that drops or reissues beats. An outbound copy whose span straddles the top of the window separates modulo indexing and the range flag from a clamped or blocked copy. Each of these also shows whether the range flag is raised or left clear as it should be. A zero-count command and a command with run cleared show the difference between a completion with no bus activity and no start at all. A register write in the middle of a transfer shows whether the lock holds.

// File: rtl/lbuf_pkg.sv
// Shared constants and types for the byte copy engine.
// Assumes: register offsets and size codes are fixed by software convention.
package lbuf_pkg;
    localparam logic [7:0] OFS_SRC = 8'h80;
    localparam logic [7:0] OFS_DST = 8'h88;
    localparam logic [7:0] OFS_CNT = 8'h90;
    localparam logic [7:0] OFS_CMD = 8'h98;

    localparam logic [1:0] SZ_WORD  = 2'b10;
    localparam logic [1:0] SZ_DWORD = 2'b11;

    localparam logic [31:0] CAUSE_COPY_DONE = 32'h0000_0100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_REQ,
        ST_RSP,
        ST_FIN
    } seq_state_t;
endpackage

// File: rtl/lbuf_regs.sv
// Setup register file: source, destination, count and command.
// Assumes: only 32-bit and 64-bit accesses are legal; the run bit locks all
// writes and is cleared by the sequencer's finish pulse.
module lbuf_regs
    import lbuf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wen,
    input  logic [7:0]  reg_addr,
    input  logic [1:0]  reg_size,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    input  logic        fin,
    output logic        go,
    output logic [63:0] src_q,
    output logic [63:0] dst_q,
    output logic [63:0] cnt_q,
    output logic [63:0] cmd_q
);
    logic        size_ok;
    logic [63:0] wval;
    logic        wr_ok;

    // Decode the access size and the write value it implies.
    always_comb begin
        size_ok = (reg_size == SZ_WORD) || (reg_size == SZ_DWORD);
        wval    = (reg_size == SZ_DWORD) ? reg_wdata : {32'h0, reg_wdata[31:0]};
        wr_ok   = reg_wen && size_ok && !cmd_q[0];
        go      = wr_ok && (reg_addr == OFS_CMD) && wval[0];
    end

    // Register update: locked while running, run cleared on finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
            cmd_q <= '0;
        end else begin
            if (fin) begin
                cmd_q[0] <= 1'b0;
            end
            if (wr_ok) begin
                case (reg_addr)
                    OFS_SRC: src_q <= wval;
                    OFS_DST: dst_q <= wval;
                    OFS_CNT: cnt_q <= wval;
                    OFS_CMD: if (wval[0]) cmd_q <= wval;
                    default: ;
                endcase
            end
        end
    end

    // Read mux: all ones for bad size or unmapped offset.
    always_comb begin
        reg_rdata = '1;
        if (size_ok) begin
            case (reg_addr)
                OFS_SRC: reg_rdata = src_q;
                OFS_DST: reg_rdata = dst_q;
                OFS_CNT: reg_rdata = cnt_q;
                OFS_CMD: reg_rdata = cmd_q;
                default: reg_rdata = '1;
            endcase
            if (reg_size == SZ_WORD) begin
                reg_rdata[63:32] = 32'h0;
            end
        end
    end

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q[0] |=> $stable(src_q) && $stable(dst_q) && $stable(cnt_q)); // R3
    AST_STOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wen && reg_addr == OFS_CMD && !reg_wdata[0] && !cmd_q[0] |=> !cmd_q[0]); // R4
endmodule

// File: rtl/lbuf_ram.sv
// Byte-wide local buffer with two ports: host byte access and engine access.
// Assumes: combinational reads; on a same-address write collision the
// engine port wins.
module lbuf_ram #(
    parameter int BYTES = 4096,
    localparam int AW   = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [7:0]    a_wdata,
    output logic [7:0]    a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [7:0]    b_wdata,
    output logic [7:0]    b_rdata
);
    logic [7:0] mem [BYTES];

    // Byte writes from both ports, engine last.
    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        if (b_we) mem[b_addr] <= b_wdata;
    end

    // Asynchronous reads for both ports.
    always_comb begin
        a_rdata = mem[a_addr];
        b_rdata = mem[b_addr];
    end
endmodule

// File: rtl/lbuf_seq.sv
// Transfer sequencer: start delay, address checks, one byte per beat.
// Assumes: setup registers stay frozen while running (locked in lbuf_regs);
// at most one beat is outstanding; read data arrives after the grant.
module lbuf_seq
    import lbuf_pkg::*;
#(
    parameter int          START_DELAY = 8,
    parameter int          EXT_AW      = 28,
    parameter int          BUF_BYTES   = 4096,
    parameter logic [63:0] BUF_BASE    = 64'h40000,
    localparam int         BUF_AW      = $clog2(BUF_BYTES),
    localparam int         DW          = $clog2(START_DELAY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [63:0]       src,
    input  logic [63:0]       dst,
    input  logic [63:0]       cnt,
    input  logic              cmd_dir,
    output logic              m_req,
    output logic              m_we,
    output logic [EXT_AW-1:0] m_addr,
    output logic [7:0]        m_wdata,
    input  logic              m_gnt,
    input  logic              m_rvalid,
    input  logic [7:0]        m_rdata,
    output logic [BUF_AW-1:0] loc_idx,
    output logic              loc_we,
    output logic [7:0]        loc_wdata,
    input  logic [7:0]        loc_rdata,
    output logic              fin,
    output logic              range_err,
    output logic              addr_clamped
);
    seq_state_t        state;
    logic [DW-1:0]     dly;
    logic [63:0]       idx;
    logic [EXT_AW-1:0] ext_base;
    logic [BUF_AW-1:0] loc_base;
    logic              dir_q;

    logic [63:0] loc_addr, ext_addr, loc_end;
    logic        span_bad, mask_hit, last_beat;

    // Start-time address analysis from the frozen registers.
    always_comb begin
        loc_addr  = cmd_dir ? src : dst;
        ext_addr  = cmd_dir ? dst : src;
        loc_end   = loc_addr + cnt;
        span_bad  = (loc_end < loc_addr) || (loc_addr < BUF_BASE) ||
                    (loc_end > BUF_BASE + 64'(BUF_BYTES));
        mask_hit  = |(ext_addr >> EXT_AW);
        last_beat = (idx + 64'd1 == cnt);
    end

    // Main state machine: delay, request, response, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            dly          <= '0;
            idx          <= '0;
            ext_base     <= '0;
            loc_base     <= '0;
            dir_q        <= 1'b0;
            range_err    <= 1'b0;
            addr_clamped <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (go) begin
                    state <= ST_WAIT;
                    dly   <= '0;
                end
                ST_WAIT: if (dly == DW'(START_DELAY - 1)) begin
                    idx          <= '0;
                    dir_q        <= cmd_dir;
                    ext_base     <= ext_addr[EXT_AW-1:0];
                    loc_base     <= BUF_AW'(loc_addr - BUF_BASE);
                    range_err    <= span_bad;
                    addr_clamped <= mask_hit;
                    state        <= (cnt == 64'd0) ? ST_FIN : ST_REQ;
                end else begin
                    dly <= dly + DW'(1);
                end
                ST_REQ: if (m_gnt) begin
                    if (!dir_q) begin
                        state <= ST_RSP;
                    end else if (last_beat) begin
                        state <= ST_FIN;
                    end else begin
                        idx <= idx + 64'd1;
                    end
                end
                ST_RSP: if (m_rvalid) begin
                    if (last_beat) begin
                        state <= ST_FIN;
                    end else begin
                        idx   <= idx + 64'd1;
                        state <= ST_REQ;
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Beat outputs and buffer port drive.
    always_comb begin
        m_req     = (state == ST_REQ);
        m_we      = dir_q;
        m_addr    = ext_base + EXT_AW'(idx);
        m_wdata   = loc_rdata;
        loc_idx   = loc_base + BUF_AW'(idx);
        loc_we    = (state == ST_RSP) && m_rvalid;
        loc_wdata = m_rdata;
        fin       = (state == ST_FIN);
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_req && !m_gnt |=> m_req && $stable(m_addr) && $stable(m_we)); // R11
endmodule

// File: rtl/lbuf_dma.sv
// Top of the single-shot byte copy engine with local 4 KiB buffer.
// Assumes: one transfer at a time; the master port grants one beat per
// request and returns read data no earlier than the cycle after the grant.
module lbuf_dma
    import lbuf_pkg::*;
#(
    parameter int          START_DELAY = 8,
    parameter int          EXT_AW      = 28,
    parameter int          BUF_BYTES   = 4096,
    parameter logic [63:0] BUF_BASE    = 64'h40000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wen,
    input  logic [7:0]                   reg_addr,
    input  logic [1:0]                   reg_size,
    input  logic [63:0]                  reg_wdata,
    output logic [63:0]                  reg_rdata,
    input  logic                         buf_wen,
    input  logic [$clog2(BUF_BYTES)-1:0] buf_addr,
    input  logic [7:0]                   buf_wdata,
    output logic [7:0]                   buf_rdata,
    output logic                         m_req,
    output logic                         m_we,
    output logic [EXT_AW-1:0]            m_addr,
    output logic [7:0]                   m_wdata,
    input  logic                         m_gnt,
    input  logic                         m_rvalid,
    input  logic [7:0]                   m_rdata,
    output logic [31:0]                  irq_raise,
    output logic                         range_err,
    output logic                         addr_clamped
);
    localparam int BUF_AW = $clog2(BUF_BYTES);

    logic              go, fin;
    logic [63:0]       src_q, dst_q, cnt_q, cmd_q;
    logic [BUF_AW-1:0] loc_idx;
    logic              loc_we;
    logic [7:0]        loc_wdata, loc_rdata;

    lbuf_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_size  (reg_size),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .fin       (fin),
        .go        (go),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .cnt_q     (cnt_q),
        .cmd_q     (cmd_q)
    );

    lbuf_seq #(
        .START_DELAY (START_DELAY),
        .EXT_AW      (EXT_AW),
        .BUF_BYTES   (BUF_BYTES),
        .BUF_BASE    (BUF_BASE)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (go),
        .src          (src_q),
        .dst          (dst_q),
        .cnt          (cnt_q),
        .cmd_dir      (cmd_q[1]),
        .m_req        (m_req),
        .m_we         (m_we),
        .m_addr       (m_addr),
        .m_wdata      (m_wdata),
        .m_gnt        (m_gnt),
        .m_rvalid     (m_rvalid),
        .m_rdata      (m_rdata),
        .loc_idx      (loc_idx),
        .loc_we       (loc_we),
        .loc_wdata    (loc_wdata),
        .loc_rdata    (loc_rdata),
        .fin          (fin),
        .range_err    (range_err),
        .addr_clamped (addr_clamped)
    );

    lbuf_ram #(.BYTES(BUF_BYTES)) u_ram (
        .clk     (clk),
        .a_we    (buf_wen),
        .a_addr  (buf_addr),
        .a_wdata (buf_wdata),
        .a_rdata (buf_rdata),
        .b_we    (loc_we),
        .b_addr  (loc_idx),
        .b_wdata (loc_wdata),
        .b_rdata (loc_rdata)
    );

    // Completion cause, present only in the finish cycle when requested.
    always_comb begin
        irq_raise = (fin && cmd_q[2]) ? CAUSE_COPY_DONE : 32'h0;
    end

    AST_IRQ_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_raise != 32'h0 |=> !cmd_q[0]); // R9
    AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> cmd_q[0]); // R6
    AST_ZERO_COUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q[0] && cnt_q == 64'h0 |-> !m_req); // R10
endmodule

// File: tb/lbuf_dma_test.sv
module lbuf_dma_test;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [1:0]  reg_size = 2'b11;
    logic [63:0] reg_wdata = 64'h0;
    logic [63:0] reg_rdata;
    logic        buf_wen = 1'b0;
    logic [11:0] buf_addr = 12'h0;
    logic [7:0]  buf_wdata = 8'h0;
    logic [7:0]  buf_rdata;
    logic        m_req, m_we;
    logic [27:0] m_addr;
    logic [7:0]  m_wdata;
    logic        m_gnt = 1'b0;
    logic        m_rvalid = 1'b0;
    logic [7:0]  m_rdata = 8'h0;
    logic [31:0] irq_raise;
    logic        range_err, addr_clamped;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [7:0] xmem [int];
    int  exp_addr [$];
    int  exp_we [$];
    int  exp_data [$];
    bit  stall_mode = 1'b0;
    int  stall_n = 0;
    bit  rd_pend = 1'b0;
    int  rd_addr = 0;

    lbuf_dma #(.START_DELAY(D)) uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_size(reg_size),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .buf_wen(buf_wen), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_gnt(m_gnt), .m_rvalid(m_rvalid), .m_rdata(m_rdata),
        .irq_raise(irq_raise), .range_err(range_err), .addr_clamped(addr_clamped)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // External memory model: grants beats, compares them with the expected
    // beat queue on every clock, returns read data one cycle after a grant.
    always @(negedge clk) begin
        if (rd_pend) begin
            m_rvalid = 1'b1;
            m_rdata  = xmem.exists(rd_addr) ? xmem[rd_addr] : 8'h00;
            rd_pend  = 1'b0;
        end else begin
            m_rvalid = 1'b0;
        end
        m_gnt = 1'b0;
        if (rst_n && m_req) begin
            stall_n++;
            if (!stall_mode || (stall_n % 3 == 0)) begin
                m_gnt = 1'b1;
                if (exp_addr.size() == 0) begin
                    chk(1'b0, "R6", "unexpected beat", 64'(m_addr), 64'h0);
                end else begin
                    chk(int'(m_addr) == exp_addr[0], "R6", "beat addr",
                        64'(m_addr), 64'(exp_addr[0]));
                    chk(int'(m_we) == exp_we[0], "R6", "beat dir",
                        64'(m_we), 64'(exp_we[0]));
                    if (m_we)
                        chk(int'(m_wdata) == exp_data[0], "R6", "beat wdata",
                            64'(m_wdata), 64'(exp_data[0]));
                    void'(exp_addr.pop_front());
                    void'(exp_we.pop_front());
                    void'(exp_data.pop_front());
                end
                if (m_we) xmem[int'(m_addr)] = m_wdata;
                else begin
                    rd_pend = 1'b1;
                    rd_addr = int'(m_addr);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [63:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_size = s; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] s, output logic [63:0] d);
        reg_addr = a; reg_size = s;
        #1;
        d = reg_rdata;
    endtask

    task automatic bwr(input int i, input logic [7:0] v);
        @(negedge clk);
        buf_wen = 1'b1; buf_addr = 12'(i); buf_wdata = v;
        @(negedge clk);
        buf_wen = 1'b0;
    endtask

    task automatic brd(input int i, output logic [7:0] v);
        buf_addr = 12'(i);
        #1;
        v = buf_rdata;
    endtask

    // Issue a command and follow it to completion; optionally try a write
    // to the source register in the middle of the run.
    task automatic run_cmd(input logic [63:0] cmdv, input bit expect_req,
                           input bit expect_irq, input bit poke);
        logic [63:0] r;
        int n, first, irqs, bad_irq;
        bit done;
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = 8'h98; reg_size = 2'b11; reg_wdata = cmdv;
        @(negedge clk);
        reg_wen = 1'b0;
        n = 1; first = -1; irqs = 0; bad_irq = 0; done = 1'b0;
        while (!done && n < 400) begin
            if (m_req && first < 0) first = n;
            if (irq_raise == 32'h100) irqs++;
            else if (irq_raise != 32'h0) bad_irq++;
            if (poke && n == 2) begin
                reg_wen = 1'b1; reg_addr = 8'h80; reg_size = 2'b11;
                reg_wdata = 64'hDEAD_BEEF;
            end else begin
                reg_wen = 1'b0;
                rd(8'h98, 2'b11, r);
                if (!r[0]) done = 1'b1;
            end
            if (!done) begin
                n++;
                @(negedge clk);
            end
        end
        chk(done, "R9", "run bit cleared", 64'(done), 64'h1);
        if (expect_req)
            chk(first == D + 1, "R5", "first request cycle", 64'(first), 64'(D + 1));
        else
            chk(first < 0, "R10", "no request for zero count", 64'(first), 64'hFFFF_FFFF_FFFF_FFFF);
        chk(irqs == (expect_irq ? 1 : 0) && bad_irq == 0, "R9", "irq pulses",
            64'(irqs), 64'(expect_irq ? 1 : 0));
        chk(exp_addr.size() == 0, "R6", "all beats issued", 64'(exp_addr.size()), 64'h0);
        chk(r == (cmdv & ~64'h1), "R9", "cmd after done", r, cmdv & ~64'h1);
    endtask

    initial begin
        logic [63:0] r;
        logic [7:0]  b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        rd(8'h80, 2'b11, r); chk(r == 64'h0, "R2", "src reset", r, 64'h0);
        rd(8'h88, 2'b11, r); chk(r == 64'h0, "R2", "dst reset", r, 64'h0);
        rd(8'h90, 2'b11, r); chk(r == 64'h0, "R2", "cnt reset", r, 64'h0);
        rd(8'h98, 2'b11, r); chk(r == 64'h0, "R2", "cmd reset", r, 64'h0);
        chk(!m_req && irq_raise == 0 && !range_err && !addr_clamped, "R2",
            "outputs idle", {m_req, irq_raise, range_err, addr_clamped}, 64'h0);

        // R1: access sizes and decode
        wr(8'h88, 2'b11, 64'h1234_5678_9ABC_DEF0);
        rd(8'h88, 2'b11, r); chk(r == 64'h1234_5678_9ABC_DEF0, "R1", "64-bit readback", r, 64'h1234_5678_9ABC_DEF0);
        rd(8'h88, 2'b10, r); chk(r == 64'h9ABC_DEF0, "R1", "32-bit read", r, 64'h9ABC_DEF0);
        wr(8'h88, 2'b10, 64'hFFFF_FFFF_1111_2222);
        rd(8'h88, 2'b11, r); chk(r == 64'h1111_2222, "R1", "32-bit write zero-ext", r, 64'h1111_2222);
        wr(8'h88, 2'b01, 64'h5555);
        rd(8'h88, 2'b11, r); chk(r == 64'h1111_2222, "R1", "bad size write ignored", r, 64'h1111_2222);
        rd(8'h88, 2'b01, r); chk(r == '1, "R1", "bad size read", r, '1);
        rd(8'h84, 2'b11, r); chk(r == '1, "R1", "unmapped read", r, '1);

        // R12: buffer byte port
        for (int i = 0; i < 5; i++) bwr(16 + i, 8'hA0 + 8'(i));
        brd(18, b); chk(b == 8'hA2, "R12", "buffer readback", 64'(b), 64'hA2);

        // Outbound copy with interrupt, mid-run write attempt (R3, R5, R6, R9)
        wr(8'h80, 2'b11, 64'h40010);
        wr(8'h88, 2'b11, 64'h1000);
        wr(8'h90, 2'b11, 64'd5);
        for (int i = 0; i < 5; i++) begin
            exp_addr.push_back(32'h1000 + i); exp_we.push_back(1); exp_data.push_back(8'hA0 + i);
        end
        run_cmd(64'h7, 1'b1, 1'b1, 1'b1);
        rd(8'h80, 2'b11, r); chk(r == 64'h40010, "R3", "src locked during run", r, 64'h40010);
        chk(xmem[32'h1004] == 8'hA4, "R6", "outbound last byte", 64'(xmem[32'h1004]), 64'hA4);
        chk(!range_err && !addr_clamped, "R8", "flags clear in-window", {range_err, addr_clamped}, 64'h0);

        // Inbound copy, stalled grants, clamped address (R6, R7, R11)
        for (int i = 0; i < 4; i++) xmem[32'h2000 + i] = 8'h50 + 8'(i);
        wr(8'h80, 2'b11, 64'h1_0000_2000);
        wr(8'h88, 2'b11, 64'h40020);
        wr(8'h90, 2'b11, 64'd4);
        for (int i = 0; i < 4; i++) begin
            exp_addr.push_back(32'h2000 + i); exp_we.push_back(0); exp_data.push_back(0);
        end
        stall_mode = 1'b1;
        run_cmd(64'h1, 1'b1, 1'b0, 1'b0);
        stall_mode = 1'b0;
        for (int i = 0; i < 4; i++) begin
            brd(32 + i, b);
            chk(b == 8'h50 + 8'(i), "R11", "inbound byte", 64'(b), 64'(8'h50 + 8'(i)));
        end
        chk(addr_clamped, "R7", "clamp flag", 64'(addr_clamped), 64'h1);

        // R4: command with run clear does nothing
        wr(8'h98, 2'b11, 64'h6);
        rd(8'h98, 2'b11, r); chk(r == 64'h0, "R4", "stop command ignored", r, 64'h0);
        begin
            int seen = 0;
            for (int i = 0; i < D + 4; i++) begin
                @(negedge clk);
                if (m_req) seen++;
            end
            chk(seen == 0, "R4", "no request after stop command", 64'(seen), 64'h0);
        end

        // R10: zero count
        wr(8'h80, 2'b11, 64'h0);
        wr(8'h88, 2'b11, 64'h40000);
        wr(8'h90, 2'b11, 64'd0);
        run_cmd(64'h5, 1'b0, 1'b1, 1'b0);
        chk(!addr_clamped && !range_err, "R7", "flags clear on zero count", {range_err, addr_clamped}, 64'h0);

        // R8: span past the top of the window wraps and is flagged
        bwr(12'hFFE, 8'h11); bwr(12'hFFF, 8'h22); bwr(0, 8'h33); bwr(1, 8'h44);
        wr(8'h80, 2'b11, 64'h40FFE);
        wr(8'h88, 2'b11, 64'h3000);
        wr(8'h90, 2'b11, 64'd4);
        exp_addr.push_back(32'h3000); exp_we.push_back(1); exp_data.push_back(8'h11);
        exp_addr.push_back(32'h3001); exp_we.push_back(1); exp_data.push_back(8'h22);
        exp_addr.push_back(32'h3002); exp_we.push_back(1); exp_data.push_back(8'h33);
        exp_addr.push_back(32'h3003); exp_we.push_back(1); exp_data.push_back(8'h44);
        run_cmd(64'h3, 1'b1, 1'b0, 1'b0);
        chk(range_err, "R8", "range flag", 64'(range_err), 64'h1);
        chk(!addr_clamped, "R7", "no clamp", 64'(addr_clamped), 64'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule